// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits behind the registered command pins of a double-data-rate SDRAM controller or memory model. On every rising clock edge it turns the select, row-strobe, column-strobe and write-enable levels, the clock-enable history, the auto-precharge address bit and the bank-select bits into one decoded command. The decoded command is presented one cycle later, together with its target bank, its address and, for column commands, the row held open in the target bank.

For each of four banks the block keeps an open/closed flag and a row register. It also follows the device power state: active, power-down or self refresh. Commands that do not fit the current bank state are still reported, but they raise an error strobe and leave the bank state untouched. Timing rules and the data path are handled elsewhere.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: In reset and on the first cycle after it, out_valid, out_err and bank_open are all 0, out_op is 0 and pwr_mode is 0 (active).
- R2: Each command sampled on a rising edge appears on the outputs after that edge. With the enable high on both the previous and the current edge, select low and strobe/row/column/write levels decode as follows. 0/0/0/0 gives op 1 (mode set); out_addr then carries the address bus and out_bank carries the bank bits. 0/1/1/1 gives op 0 with out_valid 0, and so does a high select.
- R3: 0/0/1/1 is an activate (op 2). It opens the bank named by the bank bits and stores the 12-bit address as that bank's row, and out_addr shows that row.
- R4: 0/1/0/1 is a read (op 3) and 0/1/0/0 is a write (op 4). out_addr is the address with bit 10 cleared, out_autopre equals address bit 10, and out_row is the open row of the target bank. With bit 10 high, the bank closes after the command.
- R5: 0/0/1/0 is a precharge. With address bit 10 low it is op 5 and closes only the named bank. With bit 10 high it is op 6: it closes every bank, and out_bank reads 0 whatever the bank bits are.
- R6: A read or write to a closed bank, or an activate to an open bank, raises out_err with out_valid. Such a command changes no bank flag and no row, and out_row and out_autopre read 0.
- R7: A mode set while any bank is open raises out_err. With all banks closed it raises no error.
- R8: 0/1/1/0 gives op 7 (burst stop). 0/0/0/1 with the enable high on both edges gives op 8 (auto refresh).
- R9: The 0/0/0/1 levels with the enable going high to low give op 9 (self-refresh entry) and pwr_mode 2. The next low-to-high enable gives op 10, and pwr_mode returns to 0.
- R10: A high-to-low enable with any other levels gives op 11 (power-down entry) and pwr_mode 1. The next low-to-high enable gives op 12, and pwr_mode returns to 0.
- R11: While the enable is low on both the previous and the current edge, every command is ignored: out_valid stays 0 and bank_open does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| rowstb_n | input | 1 | Row strobe level |
| colstb_n | input | 1 | Column strobe level |
| wren_n | input | 1 | Write-enable level |
| clk_en | input | 1 | Clock-enable level on this edge |
| adr_bus | input | 12 | Row, column or opcode address; bit 10 is the auto-precharge / all-banks flag |
| bank_sel | input | 2 | Bank select |
| out_valid | output | 1 | A command was decoded on the last edge |
| out_op | output | 4 | Decoded command code (see R2 to R10) |
| out_bank | output | 2 | Target bank |
| out_addr | output | 12 | Row, column or opcode |
| out_autopre | output | 1 | Read/write closes its bank |
| out_row | output | 12 | Open row of the target bank for read/write |
| out_err | output | 1 | Command illegal for the bank state |
| bank_open | output | 4 | Open flag per bank |
| pwr_mode | output | 2 | 0 active, 1 power-down, 2 self refresh |

## Verification
A bank flag that opens or closes wrongly shows on bank_open on the cycle right after the command. It shows again on the next command to that bank, as an error strobe that should not be there or is missing. A row register that is stored wrongly stays hidden until the next read or write to that bank, and then shows on out_row. A wrong power state shows on pwr_mode at once. It also shows later as the wrong exit code when the enable rises, so the bench pairs every entry with an exit and checks ignored commands between them.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 4'd0,
        OP_MRS  = 4'd1,
        OP_ACT  = 4'd2,
        OP_RD   = 4'd3,
        OP_WR   = 4'd4,
        OP_PRE  = 4'd5,
        OP_PREA = 4'd6,
        OP_BST  = 4'd7,
        OP_AREF = 4'd8,
        OP_SRE  = 4'd9,
        OP_SRX  = 4'd10,
        OP_PDE  = 4'd11,
        OP_PDX  = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_PWRDN   = 2'd1,
        PM_SELFREF = 2'd2
    } pmode_e;

    typedef struct packed {
        logic sel_n;
        logic row_n;
        logic col_n;
        logic wr_n;
    } pins_t;

    // Decode with the clock enable steady high.
    function automatic op_e decode_steady(pins_t p, logic ap);
        op_e r;
        r = OP_NONE;
        if (!p.sel_n) begin
            case ({p.row_n, p.col_n, p.wr_n})
                3'b000:  r = OP_MRS;
                3'b001:  r = OP_AREF;
                3'b010:  r = ap ? OP_PREA : OP_PRE;
                3'b011:  r = OP_ACT;
                3'b100:  r = OP_WR;
                3'b101:  r = OP_RD;
                3'b110:  r = OP_BST;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_refresh_code(pins_t p);
        return !p.sel_n && !p.row_n && !p.col_n && p.wr_n;
    endfunction

    function automatic logic is_column(op_e o);
        return (o == OP_RD) || (o == OP_WR);
    endfunction

endpackage

// File: rtl/sdct_classify.sv
module sdct_classify
    import sdct_pkg::*;
(
    input  pins_t  pins,
    input  logic   ap_bit,
    input  logic   en_now,
    input  logic   en_prev,
    input  pmode_e mode,
    output op_e    op
);
    always_comb begin
        unique case ({en_prev, en_now})
            2'b11:   op = decode_steady(pins, ap_bit);
            2'b10:   op = is_refresh_code(pins) ? OP_SRE : OP_PDE;
            2'b01:   op = (mode == PM_SELFREF) ? OP_SRX : OP_PDX;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/sdct_power.sv
module sdct_power
    import sdct_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_now,
    input  op_e    op,
    output logic   en_prev,
    output pmode_e mode
);
    pmode_e mode_q;
    logic   en_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev_q <= 1'b1;
            mode_q    <= PM_ACTIVE;
        end else begin
            en_prev_q <= en_now;
            case (op)
                OP_SRE:        mode_q <= PM_SELFREF;
                OP_PDE:        mode_q <= PM_PWRDN;
                OP_SRX, OP_PDX: mode_q <= PM_ACTIVE;
                default:       mode_q <= mode_q;
            endcase
        end
    end

    assign en_prev = en_prev_q;
    assign mode    = mode_q;

    AST_LOW_MEANS_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        !en_prev_q |-> (mode_q != PM_ACTIVE)); // R10

    AST_SREF_EXIT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_SELFREF && en_now) |=> (mode_q == PM_ACTIVE)); // R9
endmodule

// File: rtl/sdct_banks.sv
module sdct_banks
    import sdct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  op_e                  op,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     adr,
    input  logic                 ap_bit,
    output logic [NUM_BANKS-1:0] open_vec,
    output logic [ROW_W-1:0]     tgt_row,
    output logic                 err
);
    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];
    logic                 tgt_open;

    assign tgt_open = open_q[ba];
    assign tgt_row  = row_q[ba];

    always_comb begin
        err = 1'b0;
        if (is_column(op) && !tgt_open) err = 1'b1;
        if (op == OP_ACT && tgt_open)   err = 1'b1;
        if (op == OP_MRS && |open_q)    err = 1'b1;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[i] <= 1'b0;
                row_q[i]  <= '0;
            end else if (op == OP_PREA) begin
                open_q[i] <= 1'b0;
            end else if (hit && !err) begin
                case (op)
                    OP_ACT: begin
                        open_q[i] <= 1'b1;
                        row_q[i]  <= adr;
                    end
                    OP_PRE: open_q[i] <= 1'b0;
                    OP_RD, OP_WR: if (ap_bit) open_q[i] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign open_vec = open_q;

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ACT && !err) |=> open_q[$past(ba)]); // R3

    AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PREA) |=> (open_q == '0)); // R5

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        err |=> $stable(open_q)); // R6
endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
    import sdct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n,
    input  logic                 rowstb_n,
    input  logic                 colstb_n,
    input  logic                 wren_n,
    input  logic                 clk_en,
    input  logic [ROW_W-1:0]     adr_bus,
    input  logic [BA_W-1:0]      bank_sel,
    output logic                 out_valid,
    output logic [OP_W-1:0]      out_op,
    output logic [BA_W-1:0]      out_bank,
    output logic [ROW_W-1:0]     out_addr,
    output logic                 out_autopre,
    output logic [ROW_W-1:0]     out_row,
    output logic                 out_err,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [1:0]           pwr_mode
);
    localparam logic [ROW_W-1:0] AP_MASK = {{(ROW_W-1){1'b0}}, 1'b1} << AP_BIT;

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic             autopre;
        logic [ROW_W-1:0] row;
        logic             err;
    } result_t;

    pins_t            pins;
    op_e              op;
    logic             en_prev;
    pmode_e           mode;
    logic             err;
    logic [ROW_W-1:0] tgt_row;
    logic             ap_bit;
    result_t          res_d, res_q;

    assign pins   = '{sel_n: sel_n, row_n: rowstb_n, col_n: colstb_n, wr_n: wren_n};
    assign ap_bit = adr_bus[AP_BIT];

    sdct_classify u_classify (
        .pins    (pins),
        .ap_bit  (ap_bit),
        .en_now  (clk_en),
        .en_prev (en_prev),
        .mode    (mode),
        .op      (op)
    );

    sdct_power u_power (
        .clk     (clk),
        .rst     (rst),
        .en_now  (clk_en),
        .op      (op),
        .en_prev (en_prev),
        .mode    (mode)
    );

    sdct_banks #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_banks (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ba       (bank_sel),
        .adr      (adr_bus),
        .ap_bit   (ap_bit),
        .open_vec (bank_open),
        .tgt_row  (tgt_row),
        .err      (err)
    );

    always_comb begin
        res_d         = '0;
        res_d.valid   = (op != OP_NONE);
        res_d.op      = op;
        res_d.err     = err;
        case (op)
            OP_MRS, OP_ACT: begin
                res_d.bank = bank_sel;
                res_d.addr = adr_bus;
            end
            OP_RD, OP_WR: begin
                res_d.bank    = bank_sel;
                res_d.addr    = adr_bus & ~AP_MASK;
                res_d.autopre = ap_bit && !err;
                res_d.row     = err ? '0 : tgt_row;
            end
            OP_PRE: res_d.bank = bank_sel;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign out_op      = res_q.op;
    assign out_bank    = res_q.bank;
    assign out_addr    = res_q.addr;
    assign out_autopre = res_q.autopre;
    assign out_row     = res_q.row;
    assign out_err     = res_q.err;
    assign pwr_mode    = mode;

    AST_HELD_LOW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!en_prev && !clk_en) |=> (!out_valid && $stable(bank_open))); // R11

    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid); // R6
endmodule

// File: tb/sdr_cmd_tracker_tb.sv
`timescale 1ns/100ps
module sdr_cmd_tracker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, rowstb_n = 1'b1, colstb_n = 1'b1, wren_n = 1'b1;
    logic        clk_en = 1'b1;
    logic [11:0] adr_bus = '0;
    logic [1:0]  bank_sel = '0;
    logic        out_valid, out_autopre, out_err;
    logic [3:0]  out_op;
    logic [1:0]  out_bank, pwr_mode;
    logic [11:0] out_addr, out_row;
    logic [3:0]  bank_open;

    always #2.5 clk = ~clk;

    sdr_cmd_tracker u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rowstb_n(rowstb_n),
        .colstb_n(colstb_n), .wren_n(wren_n), .clk_en(clk_en),
        .adr_bus(adr_bus), .bank_sel(bank_sel), .out_valid(out_valid),
        .out_op(out_op), .out_bank(out_bank), .out_addr(out_addr),
        .out_autopre(out_autopre), .out_row(out_row), .out_err(out_err),
        .bank_open(bank_open), .pwr_mode(pwr_mode)
    );

    typedef struct {
        string       tag;
        logic        valid;
        logic [3:0]  op;
        logic [1:0]  bank;
        logic [11:0] addr;
        logic        ap;
        logic [11:0] row;
        logic        err;
        logic [3:0]  open;
        logic [1:0]  mode;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference state, built from the requirements
    logic [3:0]  m_open = '0;
    logic [11:0] m_row [4] = '{default: '0};
    logic        m_en_prev = 1'b1;
    logic [1:0]  m_mode = 2'd0;

    task automatic cmp_field(input string tag, input string nm, input logic [11:0] act,
                             input logic [11:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
            bad = 1;
        end
    endtask

    task automatic compare(input exp_t e);
        bit bad = 0;
        cmp_field(e.tag, "valid", 12'(out_valid), 12'(e.valid), bad);
        cmp_field(e.tag, "op", 12'(out_op), 12'(e.op), bad);
        cmp_field(e.tag, "bank", 12'(out_bank), 12'(e.bank), bad);
        cmp_field(e.tag, "addr", out_addr, e.addr, bad);
        cmp_field(e.tag, "autopre", 12'(out_autopre), 12'(e.ap), bad);
        cmp_field(e.tag, "row", out_row, e.row, bad);
        cmp_field(e.tag, "err", 12'(out_err), 12'(e.err), bad);
        cmp_field(e.tag, "bank_open", 12'(bank_open), 12'(e.open), bad);
        cmp_field(e.tag, "pwr_mode", 12'(pwr_mode), 12'(e.mode), bad);
        n_cmp++;
        if (bad) n_bad++;
    endtask

    function automatic exp_t predict(input string tag, input logic s, r, c, w, k,
                                     input logic [11:0] a, input logic [1:0] b);
        exp_t e;
        logic any_open;
        e = '{tag: tag, default: '0};
        any_open = |m_open;
        if (m_en_prev && k) begin
            if (!s) begin
                case ({r, c, w})
                    3'b000: begin e.op = 1; e.bank = b; e.addr = a; e.err = any_open; end
                    3'b011: begin
                        e.op = 2; e.bank = b; e.addr = a; e.err = m_open[b];
                        if (!e.err) begin m_open[b] = 1'b1; m_row[b] = a; end
                    end
                    3'b101, 3'b100: begin
                        e.op = w ? 4'd3 : 4'd4; e.bank = b; e.addr = a & 12'hBFF;
                        e.err = !m_open[b];
                        if (!e.err) begin
                            e.ap = a[10]; e.row = m_row[b];
                            if (a[10]) m_open[b] = 1'b0;
                        end
                    end
                    3'b010: begin
                        if (a[10]) begin e.op = 6; m_open = '0; end
                        else begin e.op = 5; e.bank = b; m_open[b] = 1'b0; end
                    end
                    3'b110: e.op = 7;
                    3'b001: e.op = 8;
                    default: e.op = 0;
                endcase
            end
        end else if (m_en_prev && !k) begin
            if (!s && !r && !c && w) begin e.op = 9; m_mode = 2; end
            else begin e.op = 11; m_mode = 1; end
        end else if (!m_en_prev && k) begin
            e.op = (m_mode == 2) ? 4'd10 : 4'd12;
            m_mode = 0;
        end
        m_en_prev = k;
        e.valid = (e.op != 0);
        e.open  = m_open;
        e.mode  = m_mode;
        return e;
    endfunction

    task automatic step(input string tag, input logic s, r, c, w, k,
                        input logic [11:0] a, input logic [1:0] b);
        @(negedge clk);
        sel_n = s; rowstb_n = r; colstb_n = c; wren_n = w; clk_en = k;
        adr_bus = a; bank_sel = b;
        q.push_back(predict(tag, s, r, c, w, k, a, b));
    endtask

    // monitor: result of the command sampled on an edge is checked 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            $display("FAIL watchdog expired");
            n_bad++;
            n_cmp++;
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        begin
            exp_t e0;
            e0 = '{tag: "R1 reset state", default: '0};
            compare(e0);
        end

        step("R2 nop",          0,1,1,1,1, 12'h000, 2'd0);
        step("R2 deselect",     1,0,0,0,1, 12'h000, 2'd0);
        step("R7 mrs closed",   0,0,0,0,1, 12'h5A3, 2'd2);
        step("R3 act b1",       0,0,1,1,1, 12'hABC, 2'd1);
        step("R6 act open b1",  0,0,1,1,1, 12'h123, 2'd1);
        step("R4 read b1",      0,1,0,1,1, 12'h005, 2'd1);
        step("R4 write ap b1",  0,1,0,0,1, 12'hC07, 2'd1);
        step("R6 read closed",  0,1,0,1,1, 12'h001, 2'd1);
        step("R3 act b2",       0,0,1,1,1, 12'h0FF, 2'd2);
        step("R3 act b3",       0,0,1,1,1, 12'hFFF, 2'd3);
        step("R7 mrs open",     0,0,0,0,1, 12'h111, 2'd0);
        step("R4 write b3",     0,1,0,0,1, 12'h3FF, 2'd3);
        step("R5 pre b2",       0,0,1,0,1, 12'h000, 2'd2);
        step("R8 burst stop",   0,1,1,0,1, 12'h000, 2'd0);
        step("R5 pre all",      0,0,1,0,1, 12'h400, 2'd3);
        step("R8 auto refresh", 0,0,0,1,1, 12'h000, 2'd0);
        step("R3 act b0",       0,0,1,1,1, 12'h777, 2'd0);
        step("R10 pd entry",    0,1,1,1,0, 12'h000, 2'd0);
        step("R11 ignored pre", 0,0,1,0,0, 12'h400, 2'd0);
        step("R11 ignored act", 0,0,1,1,0, 12'h222, 2'd1);
        step("R10 pd exit",     1,1,1,1,1, 12'h000, 2'd0);
        step("R4 read b0 ap",   0,1,0,1,1, 12'h408, 2'd0);
        step("R9 sref entry",   0,0,0,1,0, 12'h000, 2'd0);
        step("R11 ignored mrs", 0,0,0,0,0, 12'h000, 2'd0);
        step("R9 sref exit",    1,1,1,1,1, 12'h000, 2'd0);
        step("R2 mrs after",    0,0,0,0,1, 12'h0A5, 2'd1);
        step("R2 idle",         1,1,1,1,1, 12'h000, 2'd0);

        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule